// File: doc/BRIEF.md
# Static Backward-Taken / Forward-Not-Taken Branch Predictor

This block sits between instruction decode and fetch and decides, for every decoded conditional branch, where fetch goes next. The decision comes only from the sign of the branch displacement. A branch that jumps to a lower address, which is usually a loop closing, is guessed taken and fetch is steered to its target. A branch that jumps forward, or has a zero displacement, is guessed not taken and fetch continues with the next sequential word. No history is kept, so a given branch receives the same guess every time it is decoded.

Each guess is stored in a small in-order queue together with the address that fetch would need if the guess turns out wrong. When the execute stage reports the real outcome of the oldest outstanding branch, the block compares it with the stored guess. On a disagreement it raises a flush, hands fetch the recovery address, discards every younger outstanding guess and refuses any decode presented in that same cycle, because that instruction came from the wrong path. Two free-running counters tally the guesses made and the guesses that proved wrong.

Top module: `bp_btfnt_predictor`

## Requirements
- R1: For a valid decoded branch whose 16-bit displacement has bit 15 set, `pred_redirect` is 1 and `pred_next_pc` equals `dec_pc + 4 + (sign-extended displacement × 4)`, modulo 2^32, in the same cycle.
- R2: For a valid decoded branch whose displacement has bit 15 clear (zero included), `pred_redirect` is 0 and `pred_next_pc` equals `dec_pc + 4`.
- R3: When `dec_is_branch` is 0, `pred_redirect` is 0, `pred_next_pc` equals `dec_pc + 4` and no guess is recorded.
- R4: A resolution (`res_valid` = 1) that disagrees with a taken guess drives `flush` = 1 and `flush_pc` = that branch's PC + 4 in the same cycle.
- R5: A resolution that disagrees with a not-taken guess drives `flush` = 1 and `flush_pc` = that branch's computed target in the same cycle.
- R6: A resolution that agrees with the stored guess leaves `flush` at 0.
- R7: Resolutions are matched to outstanding branches in the order those branches were decoded, with up to DEPTH (default 4) outstanding.
- R8: In a flush cycle, `pred_redirect` is 0, the branch presented at decode is not recorded or counted, and all outstanding guesses are discarded.
- R9: `pred_count` rises by one in the cycle after each recorded guess and `mispred_count` by one in the cycle after each flush; otherwise both hold.
- R10: During and after reset, both counters read 0, no guess is outstanding and `flush` is 0.
- R11: A branch that was mispredicted receives the same guess when it is decoded again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_valid | input | 1 | An instruction is present at decode |
| dec_is_branch | input | 1 | The decoded instruction is a conditional branch |
| dec_pc | input | 32 | Address of the decoded instruction |
| dec_offset | input | 16 | Branch displacement in instruction words, two's complement |
| res_valid | input | 1 | Outcome of the oldest outstanding branch is available |
| res_taken | input | 1 | That outcome: 1 taken, 0 not taken |
| pred_next_pc | output | 32 | Address fetch uses next when no flush is raised |
| pred_redirect | output | 1 | Fetch is steered away from the sequential address |
| flush | output | 1 | Wrong-path work must be squashed |
| flush_pc | output | 32 | Recovery fetch address, meaningful while `flush` is 1 |
| pred_count | output | 32 | Number of guesses recorded since reset |
| mispred_count | output | 32 | Number of wrong guesses since reset |

## Verification
The assertions take for granted that the execute stage reports an outcome only while a guess is outstanding, and that decode never presents a new branch while DEPTH guesses wait unless one resolves in the same cycle. The stimulus keeps within both by resolving every recorded branch before recording more than three further ones, and by never raising `res_valid` after a flush until a fresh branch has been recorded. Under those conditions the properties tie the counters, the queue occupancy and the flush to one another across cycles.

// File: rtl/bp_pkg.sv
package bp_pkg;

   // Direction guess attached to each recorded branch.
   typedef enum logic {
      GUESS_SEQ  = 1'b0,
      GUESS_JUMP = 1'b1
   } guess_e;

endpackage

// File: rtl/bp_dir_unit.sv
// Derives the sequential address, the branch target and the direction
// guess from the decoded fields. Pure combinational logic.
module bp_dir_unit
   import bp_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int DISP_W     = 16,
   parameter int WORD_BYTES = 4
) (
   input  logic              is_branch,
   input  logic [ADDR_W-1:0] pc,
   input  logic [DISP_W-1:0] disp,
   output logic [ADDR_W-1:0] seq_pc,
   output logic [ADDR_W-1:0] target_pc,
   output guess_e            guess
);

   localparam int SCALE_SH = $clog2(WORD_BYTES);

   logic [ADDR_W-1:0] disp_ext;
   logic [ADDR_W-1:0] disp_bytes;

   generate
      if (DISP_W == ADDR_W) begin : g_full_disp
         assign disp_ext = disp;
      end else begin : g_sext_disp
         assign disp_ext = {{(ADDR_W-DISP_W){disp[DISP_W-1]}}, disp};
      end
   endgenerate

   assign disp_bytes = disp_ext << SCALE_SH;
   assign seq_pc     = pc + ADDR_W'(WORD_BYTES);
   assign target_pc  = seq_pc + disp_bytes;
   // Sign bit alone chooses the direction; zero displacement is forward.
   assign guess      = (is_branch && disp[DISP_W-1]) ? GUESS_JUMP : GUESS_SEQ;

endmodule

// File: rtl/bp_inflight_q.sv
// In-order queue of outstanding guesses. A clear empties it at once.
module bp_inflight_q #(
   parameter int WIDTH = 33,
   parameter int DEPTH = 4,
   localparam int OCC_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             push,
   input  logic [WIDTH-1:0] push_data,
   input  logic             pop,
   output logic [WIDTH-1:0] head_data,
   output logic             empty,
   output logic             full,
   output logic [OCC_W-1:0] occupancy
);

   generate
      if (DEPTH == 1) begin : g_single
         logic             held;
         logic [WIDTH-1:0] slot;

         always_ff @(posedge clk) begin
            if (!rst_n || clear) begin
               held <= 1'b0;
            end else if (push && (!held || pop)) begin
               held <= 1'b1;
            end else if (pop) begin
               held <= 1'b0;
            end
         end

         always_ff @(posedge clk) begin
            if (push && (!held || pop)) slot <= push_data;
         end

         assign head_data = slot;
         assign empty     = !held;
         assign full      = held;
         assign occupancy = OCC_W'(held);
      end else begin : g_ring
         localparam int PTR_W = $clog2(DEPTH);

         logic [WIDTH-1:0] store [DEPTH];
         logic [PTR_W-1:0] rd_ptr;
         logic [PTR_W-1:0] wr_ptr;
         logic [OCC_W-1:0] fill;
         logic             take;
         logic             put;

         function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
            return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
         endfunction

         assign take = pop && (fill != '0);
         assign put  = push && ((fill != OCC_W'(DEPTH)) || take);

         always_ff @(posedge clk) begin
            if (!rst_n || clear) begin
               rd_ptr <= '0;
               wr_ptr <= '0;
               fill   <= '0;
            end else begin
               if (put)  wr_ptr <= step(wr_ptr);
               if (take) rd_ptr <= step(rd_ptr);
               case ({put, take})
                  2'b10:   fill <= fill + OCC_W'(1);
                  2'b01:   fill <= fill - OCC_W'(1);
                  default: fill <= fill;
               endcase
            end
         end

         always_ff @(posedge clk) begin
            if (put && !clear) store[wr_ptr] <= push_data;
         end

         assign head_data = store[rd_ptr];
         assign empty     = (fill == '0);
         assign full      = (fill == OCC_W'(DEPTH));
         assign occupancy = fill;
      end
   endgenerate

endmodule

// File: rtl/bp_event_ctr.sv
// Free-running event counter, wraps at its width.
module bp_event_ctr #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bump,
   output logic [CNT_W-1:0] value
);

   always_ff @(posedge clk) begin
      if (!rst_n)    value <= '0;
      else if (bump) value <= value + CNT_W'(1);
   end

endmodule

// File: rtl/bp_btfnt_predictor.sv
module bp_btfnt_predictor
   import bp_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int DISP_W     = 16,
   parameter int WORD_BYTES = 4,
   parameter int DEPTH      = 4,
   parameter int CNT_W      = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dec_valid,
   input  logic              dec_is_branch,
   input  logic [ADDR_W-1:0] dec_pc,
   input  logic [DISP_W-1:0] dec_offset,
   input  logic              res_valid,
   input  logic              res_taken,
   output logic [ADDR_W-1:0] pred_next_pc,
   output logic              pred_redirect,
   output logic              flush,
   output logic [ADDR_W-1:0] flush_pc,
   output logic [CNT_W-1:0]  pred_count,
   output logic [CNT_W-1:0]  mispred_count
);

   localparam int OCC_W = $clog2(DEPTH + 1);

   typedef struct packed {
      guess_e            guess;
      logic [ADDR_W-1:0] alt_pc;
   } pending_t;

   localparam int PEND_W = $bits(pending_t);

   // Elaboration-time parameter checks.
   generate
      if (DISP_W < 2 || DISP_W > ADDR_W) begin : g_bad_disp
         $error("DISP_W must lie between 2 and ADDR_W");
      end
      if (WORD_BYTES < 1 || (WORD_BYTES & (WORD_BYTES - 1)) != 0) begin : g_bad_word
         $error("WORD_BYTES must be a power of two");
      end
      if (DEPTH < 1) begin : g_bad_depth
         $error("DEPTH must be at least 1");
      end
      if (CNT_W < 1) begin : g_bad_cnt
         $error("CNT_W must be at least 1");
      end
   endgenerate

   logic [ADDR_W-1:0] seq_pc;
   logic [ADDR_W-1:0] target_pc;
   guess_e            guess;
   pending_t          head;
   pending_t          entry;
   logic [PEND_W-1:0] head_bits;
   logic              q_empty;
   logic              q_full;
   logic [OCC_W-1:0]  q_occ;
   logic              retire;
   logic              wrong;
   logic              accept;

   bp_dir_unit #(
      .ADDR_W    (ADDR_W),
      .DISP_W    (DISP_W),
      .WORD_BYTES(WORD_BYTES)
   ) u_dir (
      .is_branch(dec_valid && dec_is_branch),
      .pc       (dec_pc),
      .disp     (dec_offset),
      .seq_pc   (seq_pc),
      .target_pc(target_pc),
      .guess    (guess)
   );

   // Resolution side: compare the oldest guess with the real outcome.
   assign head   = pending_t'(head_bits);
   assign retire = res_valid && !q_empty;
   assign wrong  = retire && ((head.guess == GUESS_JUMP) != res_taken);
   assign flush    = wrong;
   assign flush_pc = wrong ? head.alt_pc : '0;

   // Decode side: wrong-path decodes are refused during a flush.
   assign accept        = dec_valid && dec_is_branch && !wrong;
   assign pred_redirect = accept && (guess == GUESS_JUMP);
   assign pred_next_pc  = pred_redirect ? target_pc : seq_pc;

   assign entry.guess  = guess;
   assign entry.alt_pc = (guess == GUESS_JUMP) ? seq_pc : target_pc;

   bp_inflight_q #(
      .WIDTH(PEND_W),
      .DEPTH(DEPTH)
   ) u_queue (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (wrong),
      .push     (accept),
      .push_data(entry),
      .pop      (retire),
      .head_data(head_bits),
      .empty    (q_empty),
      .full     (q_full),
      .occupancy(q_occ)
   );

   bp_event_ctr #(.CNT_W(CNT_W)) u_pred_ctr (
      .clk  (clk),
      .rst_n(rst_n),
      .bump (accept),
      .value(pred_count)
   );

   bp_event_ctr #(.CNT_W(CNT_W)) u_miss_ctr (
      .clk  (clk),
      .rst_n(rst_n),
      .bump (wrong),
      .value(mispred_count)
   );

   // Input assumptions: outcomes only for outstanding guesses, no overrun.
   a_res_has_entry: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> !q_empty);
   a_dec_has_room: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !retire) |-> !q_full);

   // R7: occupancy never exceeds the queue depth.
   a_r7_occ_bound: assert property (@(posedge clk) disable iff (!rst_n)
      q_occ <= OCC_W'(DEPTH));
   // R8: a flush leaves no outstanding guess behind.
   a_r8_flush_drains: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> q_empty);
   // R8: no redirect is offered while recovering.
   a_r8_quiet_redirect: assert property (@(posedge clk) disable iff (!rst_n)
      flush |-> !pred_redirect);
   // R9: counter steps follow recorded guesses and flushes.
   a_r9_pred_step: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> pred_count == $past(pred_count) + CNT_W'(1));
   a_r9_pred_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !accept |=> $stable(pred_count));
   a_r9_miss_step: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> mispred_count == $past(mispred_count) + CNT_W'(1));
   // R10: a flush always needs an outstanding guess, so none right after reset.
   a_r10_reset_idle: assert property (@(posedge clk)
      !rst_n |=> (q_empty && pred_count == '0 && mispred_count == '0));

endmodule

// File: tb/bp_btfnt_predictor_test.sv
`timescale 1ns/1ps
module bp_btfnt_predictor_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        dec_valid = 1'b0;
   logic        dec_is_branch = 1'b0;
   logic [31:0] dec_pc = '0;
   logic [15:0] dec_offset = '0;
   logic        res_valid = 1'b0;
   logic        res_taken = 1'b0;
   logic [31:0] pred_next_pc;
   logic        pred_redirect;
   logic        flush;
   logic [31:0] flush_pc;
   logic [31:0] pred_count;
   logic [31:0] mispred_count;

   int n_checks = 0;
   int n_fail   = 0;
   int exp_pred = 0;
   int exp_miss = 0;
   bit done     = 1'b0;

   always #4 clk = ~clk;

   bp_btfnt_predictor uut (
      .clk          (clk),
      .rst_n        (rst_n),
      .dec_valid    (dec_valid),
      .dec_is_branch(dec_is_branch),
      .dec_pc       (dec_pc),
      .dec_offset   (dec_offset),
      .res_valid    (res_valid),
      .res_taken    (res_taken),
      .pred_next_pc (pred_next_pc),
      .pred_redirect(pred_redirect),
      .flush        (flush),
      .flush_pc     (flush_pc),
      .pred_count   (pred_count),
      .mispred_count(mispred_count)
   );

   typedef struct packed {
      logic        br;
      logic [31:0] pc;
      logic [15:0] off;
      logic        redir;
      logic [31:0] nxt;
   } vec_t;

   localparam int NV = 9;
   localparam vec_t VECS [NV] = '{
      '{1'b1, 32'h0000_1000, 16'hFFFF, 1'b1, 32'h0000_1000},  // R1
      '{1'b1, 32'h0000_1000, 16'h0000, 1'b0, 32'h0000_1004},  // R2 zero
      '{1'b1, 32'h0000_1000, 16'h0010, 1'b0, 32'h0000_1004},  // R2
      '{1'b1, 32'h0000_2000, 16'h8000, 1'b1, 32'hFFFE_2004},  // R1 most negative
      '{1'b1, 32'h0000_2000, 16'h7FFF, 1'b0, 32'h0000_2004},  // R2 most positive
      '{1'b0, 32'h0000_3000, 16'hFFF0, 1'b0, 32'h0000_3004},  // R3
      '{1'b1, 32'h0000_0000, 16'hFFFE, 1'b1, 32'hFFFF_FFFC},  // R1 wrap below 0
      '{1'b1, 32'hFFFF_FFFC, 16'hFFFF, 1'b1, 32'hFFFF_FFFC},  // R1 wrap above top
      '{1'b1, 32'h0000_0010, 16'hFFFD, 1'b1, 32'h0000_0008}   // R1
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic idle();
      dec_valid = 1'b0; dec_is_branch = 1'b0; res_valid = 1'b0; res_taken = 1'b0;
   endtask

   task automatic decode(input logic br, input logic [31:0] pc, input logic [15:0] off);
      dec_valid = 1'b1; dec_is_branch = br; dec_pc = pc; dec_offset = off;
   endtask

   task automatic resolve(input logic tk);
      res_valid = 1'b1; res_taken = tk;
   endtask

   initial begin
      // R10: reset state
      repeat (3) @(negedge clk);
      #2;
      chk("R10 pred_count", pred_count, 32'd0);
      chk("R10 mispred_count", mispred_count, 32'd0);
      chk("R10 flush", {31'd0, flush}, 32'd0);
      @(negedge clk);
      rst_n = 1'b1;

      // Vector walk: guess at decode, then an agreeing resolution (R6).
      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         idle();
         decode(VECS[i].br, VECS[i].pc, VECS[i].off);
         #2;
         chk("R1/R2/R3 next_pc", pred_next_pc, VECS[i].nxt);
         chk("R1/R2/R3 redirect", {31'd0, pred_redirect}, {31'd0, VECS[i].redir});
         if (VECS[i].br) begin
            exp_pred++;
            @(negedge clk);
            idle();
            resolve(VECS[i].redir);
            #2;
            chk("R6 agree no flush", {31'd0, flush}, 32'd0);
         end
      end
      @(negedge clk);
      idle();
      #2;
      chk("R9 pred_count", pred_count, exp_pred);
      chk("R9 mispred_count", mispred_count, exp_miss);
      chk("R3 non-branch not counted", pred_count, 32'd8);

      // R4: taken guess proves wrong; same-cycle decode is refused (R8).
      @(negedge clk);
      decode(1'b1, 32'h0000_0100, 16'hFFF8);
      #2;
      chk("R1 backward target", pred_next_pc, 32'h0000_00E4);
      exp_pred++;
      @(negedge clk);
      idle();
      decode(1'b1, 32'h0000_0180, 16'hFFFF);
      resolve(1'b0);
      #2;
      chk("R4 flush", {31'd0, flush}, 32'd1);
      chk("R4 flush_pc", flush_pc, 32'h0000_0104);
      chk("R8 no redirect in flush", {31'd0, pred_redirect}, 32'd0);
      exp_miss++;
      @(negedge clk);
      idle();
      #2;
      chk("R8 refused decode not counted", pred_count, exp_pred);
      chk("R9 mispred_count after flush", mispred_count, exp_miss);

      // R11: the same branch gets the same guess again.
      decode(1'b1, 32'h0000_0100, 16'hFFF8);
      #2;
      chk("R11 same redirect", {31'd0, pred_redirect}, 32'd1);
      chk("R11 same target", pred_next_pc, 32'h0000_00E4);
      exp_pred++;
      @(negedge clk);
      idle();
      resolve(1'b1);
      #2;
      chk("R6 agree taken", {31'd0, flush}, 32'd0);

      // R5: not-taken guess proves wrong.
      @(negedge clk);
      idle();
      decode(1'b1, 32'h0000_0200, 16'h0040);
      #2;
      chk("R2 forward sequential", pred_next_pc, 32'h0000_0204);
      exp_pred++;
      @(negedge clk);
      idle();
      resolve(1'b1);
      #2;
      chk("R5 flush", {31'd0, flush}, 32'd1);
      chk("R5 flush_pc", flush_pc, 32'h0000_0304);
      exp_miss++;

      // R7: in-order matching with three outstanding; R8 discards the rest.
      @(negedge clk);
      idle();
      decode(1'b1, 32'h0000_0400, 16'hFFFF);
      exp_pred++;
      @(negedge clk);
      decode(1'b1, 32'h0000_0500, 16'h0004);
      exp_pred++;
      @(negedge clk);
      decode(1'b1, 32'h0000_0600, 16'hFFFE);
      exp_pred++;
      @(negedge clk);
      idle();
      resolve(1'b1);
      #2;
      chk("R7 oldest agrees", {31'd0, flush}, 32'd0);
      @(negedge clk);
      resolve(1'b1);
      #2;
      chk("R7 second mispredicts", {31'd0, flush}, 32'd1);
      chk("R7 second recovery", flush_pc, 32'h0000_0514);
      exp_miss++;
      @(negedge clk);
      idle();
      decode(1'b1, 32'h0000_0700, 16'h0001);
      exp_pred++;
      @(negedge clk);
      idle();
      resolve(1'b0);
      #2;
      chk("R8 younger discarded", {31'd0, flush}, 32'd0);
      @(negedge clk);
      idle();
      #2;
      chk("R9 final pred_count", pred_count, exp_pred);
      chk("R9 final mispred_count", mispred_count, exp_miss);

      // R10: reset applied mid-run clears the counters.
      rst_n = 1'b0;
      @(negedge clk);
      #2;
      chk("R10 counters cleared", pred_count | mispred_count, 32'd0);
      rst_n = 1'b1;

      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

endmodule